// File: doc/BRIEF.md
# Display Controller Indexed Register Port

This block is the byte-wide register front end of a legacy-style display controller. Three register banks sit behind their own index/data port pairs: sequencer, CRT timing and graphics. A write to an index port picks the register. Later accesses to the matching data port read or write that register. The contents of every bank come out as flat vectors, which feed the downstream timing and format logic.

A single palette mask port also guards a hidden pixel-format register. After four mask-port reads with no other access between them, the next write to that port goes into the hidden register and the mask is left alone. The block also decodes two values for the pixel datapath:
- the colour class, taken from the hidden register;
- the bits per pixel, taken from the low five bits of sequencer register 7.

Top module: `dispctl_regport`

## Requirements
- R1: A synchronous active-low reset clears every register to zero, including the indexes, the mask, the hidden register and the read run counter.
- R2: The port offsets are fixed:
  - sequencer index at 0x04 and sequencer data at 0x05;
  - graphics index at 0x0E and graphics data at 0x0F;
  - CRT index at 0x14 and CRT data at 0x15;
  - palette mask at 0x06.
  
  A read of an index port returns the stored index.
- R3: A data-port write stores the byte in the register chosen by that bank's current index. A data-port read in the same access cycle returns that register on acc_rdata.
- R4: An index at or above the bank size (sequencer 8, CRT 32, graphics 16) reads as zero through the data port, and a write through it changes no register.
- R5: After four mask-port reads with no other access between them, a mask-port write stores its byte in the hidden register and leaves the mask unchanged.
- R6: Any access to a port other than the mask port clears the read run. So does a mask-port write made before the fourth read, and that write goes to the mask.
- R7: After a hidden write, the run restarts from zero. Reads beyond the fourth keep the port armed.
- R8: color_mode decodes the hidden register as follows: 0x00 gives 0 (8-bit indexed), 0xC1 gives 1 (16-bit 5:6:5), 0xC5 gives 2 (24/32-bit direct), and any other value gives 3.
- R9: pix_bpp decodes bits 4:0 of sequencer register 7 as follows: 0x11 gives 8, 0x17 gives 16, 0x15 gives 24, 0x19 gives 32, and any other code gives 0. Bits 7:5 do not affect the decode.
- R10: A cycle with acc_en low changes no state. A read of an offset with no port returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| acc_en | input | 1 | Access valid this cycle |
| acc_wr | input | 1 | 1 for write, 0 for read |
| acc_addr | input | ADDR_W | Byte offset of the port |
| acc_wdata | input | 8 | Write byte |
| acc_rdata | output | 8 | Read byte, combinational from the current access |
| seq_regs | output | SEQ_N*8 | Sequencer registers, register i in bits 8i+7:8i |
| crt_regs | output | CRT_N*8 | CRT registers, same packing |
| gfx_regs | output | GFX_N*8 | Graphics registers, same packing |
| pal_mask | output | 8 | Palette mask register |
| pix_fmt | output | 8 | Hidden pixel-format register |
| color_mode | output | 2 | Decoded colour class |
| pix_bpp | output | 6 | Decoded bits per pixel |

## Verification
The assertions check the unlock sequence on every cycle:
- the run counter stays bounded;
- an armed mask write lands only in the hidden register, and an unarmed one lands only in the mask;
- any foreign access, or any hidden write, returns the run to zero;
- idle cycles hold all state.

The bank storage, the behaviour of out-of-range indexes and the two decoders can only be shown by the bench's scenarios. These include the interrupted and over-long read runs, and a long random mix of accesses compared against a reference model.

// File: rtl/dispctl_regport.sv
module dispctl_regport #(
  parameter int SEQ_N     = 8,
  parameter int CRT_N     = 32,
  parameter int GFX_N     = 16,
  parameter int ADDR_W    = 8,
  parameter int DEPTH_REG = 7
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 acc_en,
  input  logic                 acc_wr,
  input  logic [ADDR_W-1:0]    acc_addr,
  input  logic [7:0]           acc_wdata,
  output logic [7:0]           acc_rdata,
  output logic [SEQ_N*8-1:0]   seq_regs,
  output logic [CRT_N*8-1:0]   crt_regs,
  output logic [GFX_N*8-1:0]   gfx_regs,
  output logic [7:0]           pal_mask,
  output logic [7:0]           pix_fmt,
  output logic [1:0]           color_mode,
  output logic [5:0]           pix_bpp
);

  localparam logic [ADDR_W-1:0] A_SEQ_I = ADDR_W'(8'h04);
  localparam logic [ADDR_W-1:0] A_SEQ_D = ADDR_W'(8'h05);
  localparam logic [ADDR_W-1:0] A_MASK  = ADDR_W'(8'h06);
  localparam logic [ADDR_W-1:0] A_GFX_I = ADDR_W'(8'h0E);
  localparam logic [ADDR_W-1:0] A_GFX_D = ADDR_W'(8'h0F);
  localparam logic [ADDR_W-1:0] A_CRT_I = ADDR_W'(8'h14);
  localparam logic [ADDR_W-1:0] A_CRT_D = ADDR_W'(8'h15);
  localparam int SEQ_W = (SEQ_N > 1) ? $clog2(SEQ_N) : 1;
  localparam int CRT_W = (CRT_N > 1) ? $clog2(CRT_N) : 1;
  localparam int GFX_W = (GFX_N > 1) ? $clog2(GFX_N) : 1;
  localparam logic [8:0] SEQ_LIM = 9'(SEQ_N);
  localparam logic [8:0] CRT_LIM = 9'(CRT_N);
  localparam logic [8:0] GFX_LIM = 9'(GFX_N);
  localparam logic [2:0] ARMED = 3'd4;

  logic [7:0] seq_q [SEQ_N];
  logic [7:0] crt_q [CRT_N];
  logic [7:0] gfx_q [GFX_N];
  logic [7:0] seq_idx, crt_idx, gfx_idx;
  logic [7:0] mask_q, fmt_q;
  logic [2:0] rd_run;

  wire hit_mask = acc_en && acc_addr == A_MASK;
  wire seq_ok = {1'b0, seq_idx} < SEQ_LIM;
  wire crt_ok = {1'b0, crt_idx} < CRT_LIM;
  wire gfx_ok = {1'b0, gfx_idx} < GFX_LIM;
  wire wr_seq = acc_en && acc_wr && acc_addr == A_SEQ_D && seq_ok;
  wire wr_crt = acc_en && acc_wr && acc_addr == A_CRT_D && crt_ok;
  wire wr_gfx = acc_en && acc_wr && acc_addr == A_GFX_D && gfx_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seq_idx <= '0;
      crt_idx <= '0;
      gfx_idx <= '0;
    end else if (acc_en && acc_wr) begin
      if (acc_addr == A_SEQ_I) seq_idx <= acc_wdata;
      if (acc_addr == A_CRT_I) crt_idx <= acc_wdata;
      if (acc_addr == A_GFX_I) gfx_idx <= acc_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < SEQ_N; i++) seq_q[i] <= '0;
    end else if (wr_seq) begin
      seq_q[seq_idx[SEQ_W-1:0]] <= acc_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < CRT_N; i++) crt_q[i] <= '0;
    end else if (wr_crt) begin
      crt_q[crt_idx[CRT_W-1:0]] <= acc_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < GFX_N; i++) gfx_q[i] <= '0;
    end else if (wr_gfx) begin
      gfx_q[gfx_idx[GFX_W-1:0]] <= acc_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '0;
      fmt_q  <= '0;
      rd_run <= '0;
    end else if (acc_en) begin
      if (!hit_mask) begin
        rd_run <= '0;
      end else if (!acc_wr) begin
        if (rd_run != ARMED) rd_run <= rd_run + 3'd1;
      end else begin
        if (rd_run == ARMED) fmt_q <= acc_wdata;
        else mask_q <= acc_wdata;
        rd_run <= '0;
      end
    end
  end

  always_comb begin
    acc_rdata = '0;
    if (acc_en) begin
      unique case (acc_addr)
        A_SEQ_I: acc_rdata = seq_idx;
        A_SEQ_D: acc_rdata = seq_ok ? seq_q[seq_idx[SEQ_W-1:0]] : '0;
        A_MASK:  acc_rdata = mask_q;
        A_GFX_I: acc_rdata = gfx_idx;
        A_GFX_D: acc_rdata = gfx_ok ? gfx_q[gfx_idx[GFX_W-1:0]] : '0;
        A_CRT_I: acc_rdata = crt_idx;
        A_CRT_D: acc_rdata = crt_ok ? crt_q[crt_idx[CRT_W-1:0]] : '0;
        default: acc_rdata = '0;
      endcase
    end
  end

  for (genvar g = 0; g < SEQ_N; g++) begin : g_seq_out
    assign seq_regs[g*8 +: 8] = seq_q[g];
  end
  for (genvar g = 0; g < CRT_N; g++) begin : g_crt_out
    assign crt_regs[g*8 +: 8] = crt_q[g];
  end
  for (genvar g = 0; g < GFX_N; g++) begin : g_gfx_out
    assign gfx_regs[g*8 +: 8] = gfx_q[g];
  end

  assign pal_mask = mask_q;
  assign pix_fmt  = fmt_q;

  always_comb begin
    unique case (fmt_q)
      8'h00:   color_mode = 2'd0;
      8'hC1:   color_mode = 2'd1;
      8'hC5:   color_mode = 2'd2;
      default: color_mode = 2'd3;
    endcase
  end

  always_comb begin
    unique case (seq_q[DEPTH_REG][4:0])
      5'h11:   pix_bpp = 6'd8;
      5'h17:   pix_bpp = 6'd16;
      5'h15:   pix_bpp = 6'd24;
      5'h19:   pix_bpp = 6'd32;
      default: pix_bpp = 6'd0;
    endcase
  end

endmodule

// File: rtl/dispctl_regport_chk.sv
module dispctl_regport_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_en,
  input logic              acc_wr,
  input logic [ADDR_W-1:0] acc_addr,
  input logic [7:0]        acc_wdata,
  input logic [7:0]        pal_mask,
  input logic [7:0]        pix_fmt,
  input logic [2:0]        rd_run
);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(8'h06);

  wire mask_wr  = acc_en && acc_wr && acc_addr == A_MASK;
  wire armed_wr = mask_wr && rd_run == 3'd4;
  wire plain_wr = mask_wr && rd_run != 3'd4;

  p_run_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_run <= 3'd4);

  p_hidden_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    armed_wr |=> pix_fmt == $past(acc_wdata) && $stable(pal_mask));

  p_mask_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    plain_wr |=> pal_mask == $past(acc_wdata) && $stable(pix_fmt) && rd_run == 3'd0);

  p_other_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && acc_addr != A_MASK) |=> rd_run == 3'd0);

  p_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    armed_wr |=> rd_run == 3'd0);

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_en |=> $stable(rd_run) && $stable(pix_fmt) && $stable(pal_mask));
endmodule

bind dispctl_regport dispctl_regport_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr),
  .acc_addr(acc_addr), .acc_wdata(acc_wdata), .pal_mask(pal_mask),
  .pix_fmt(pix_fmt), .rd_run(rd_run)
);

// File: tb/dispctl_regport_tb.sv
module dispctl_regport_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acc_en = 1'b0, acc_wr = 1'b0;
  logic [7:0] acc_addr = '0, acc_wdata = '0;
  logic [7:0] acc_rdata, pal_mask, pix_fmt;
  logic [63:0] seq_regs;
  logic [255:0] crt_regs;
  logic [127:0] gfx_regs;
  logic [1:0] color_mode;
  logic [5:0] pix_bpp;

  int checks = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dispctl_regport u_dut (
    .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
    .seq_regs(seq_regs), .crt_regs(crt_regs), .gfx_regs(gfx_regs),
    .pal_mask(pal_mask), .pix_fmt(pix_fmt), .color_mode(color_mode),
    .pix_bpp(pix_bpp)
  );

  logic [7:0] m_seq [8];
  logic [7:0] m_crt [32];
  logic [7:0] m_gfx [16];
  logic [7:0] m_si, m_ci, m_gi, m_mask, m_fmt;
  int m_run;

  function automatic logic [1:0] exp_mode(logic [7:0] f);
    if (f == 8'h00) return 2'd0;
    if (f == 8'hC1) return 2'd1;
    if (f == 8'hC5) return 2'd2;
    return 2'd3;
  endfunction

  function automatic logic [5:0] exp_bpp(logic [7:0] r);
    case (r[4:0])
      5'h11: return 6'd8;
      5'h17: return 6'd16;
      5'h15: return 6'd24;
      5'h19: return 6'd32;
      default: return 6'd0;
    endcase
  endfunction

  function automatic logic [7:0] m_read(logic [7:0] a);
    case (a)
      8'h04: return m_si;
      8'h05: return (m_si < 8) ? m_seq[m_si[2:0]] : 8'h00;
      8'h06: return m_mask;
      8'h0E: return m_gi;
      8'h0F: return (m_gi < 16) ? m_gfx[m_gi[3:0]] : 8'h00;
      8'h14: return m_ci;
      8'h15: return (m_ci < 32) ? m_crt[m_ci[4:0]] : 8'h00;
      default: return 8'h00;
    endcase
  endfunction

  task automatic m_reset();
    for (int i = 0; i < 8; i++) m_seq[i] = '0;
    for (int i = 0; i < 32; i++) m_crt[i] = '0;
    for (int i = 0; i < 16; i++) m_gfx[i] = '0;
    m_si = '0; m_ci = '0; m_gi = '0; m_mask = '0; m_fmt = '0; m_run = 0;
  endtask

  task automatic m_update(logic wr, logic [7:0] a, logic [7:0] d);
    if (a != 8'h06) m_run = 0;
    if (!wr) begin
      if (a == 8'h06 && m_run < 4) m_run++;
    end else begin
      case (a)
        8'h04: m_si = d;
        8'h05: if (m_si < 8) m_seq[m_si[2:0]] = d;
        8'h0E: m_gi = d;
        8'h0F: if (m_gi < 16) m_gfx[m_gi[3:0]] = d;
        8'h14: m_ci = d;
        8'h15: if (m_ci < 32) m_crt[m_ci[4:0]] = d;
        8'h06: begin
          if (m_run == 4) m_fmt = d; else m_mask = d;
          m_run = 0;
        end
        default: ;
      endcase
    end
  endtask

  task automatic chk(string req, logic [255:0] act, logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic acc(logic wr, logic [7:0] a, logic [7:0] d, string req);
    @(negedge clk);
    acc_en = 1'b1; acc_wr = wr; acc_addr = a; acc_wdata = d;
    #1;
    if (!wr) chk(req, 256'(acc_rdata), 256'(m_read(a)));
    m_update(wr, a, d);
    @(posedge clk);
    #1;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      acc_en = 1'b0;
      acc_wr = 1'b0;
      acc_wdata = 8'hA5;
    end
    @(posedge clk);
    #1;
  endtask

  task automatic mask_reads(int n, string req);
    for (int i = 0; i < n; i++) acc(1'b0, 8'h06, 8'h00, req);
  endtask

  task automatic chk_outputs(string req);
    logic [63:0] s;
    logic [255:0] c;
    logic [127:0] g;
    for (int i = 0; i < 8; i++) s[i*8 +: 8] = m_seq[i];
    for (int i = 0; i < 32; i++) c[i*8 +: 8] = m_crt[i];
    for (int i = 0; i < 16; i++) g[i*8 +: 8] = m_gfx[i];
    chk({req, " seq"}, 256'(seq_regs), 256'(s));
    chk({req, " crt"}, crt_regs, c);
    chk({req, " gfx"}, 256'(gfx_regs), 256'(g));
    chk({req, " mask"}, 256'(pal_mask), 256'(m_mask));
    chk({req, " fmt"}, 256'(pix_fmt), 256'(m_fmt));
    chk({req, " mode"}, 256'(color_mode), 256'(exp_mode(m_fmt)));
    chk({req, " bpp"}, 256'(pix_bpp), 256'(exp_bpp(m_seq[7])));
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      bad++;
      checks++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] pool [9];
    pool = '{8'h04, 8'h05, 8'h06, 8'h0E, 8'h0F, 8'h14, 8'h15, 8'h00, 8'h1F};
    void'($urandom(32'd20240611));
    m_reset();
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    // R1: reset state
    chk_outputs("R1");
    acc(1'b0, 8'h05, 8'h00, "R1 seq data");
    acc(1'b0, 8'h14, 8'h00, "R1 crt index");
    // R2, R3, R9: depth register, with the upper bits set
    acc(1'b1, 8'h04, 8'h07, "R2");
    acc(1'b0, 8'h04, 8'h00, "R2 seq index readback");
    acc(1'b1, 8'h05, 8'hF9, "R3");
    acc(1'b0, 8'h05, 8'h00, "R3 seq readback");
    chk("R9 bpp 32 upper bits set", 256'(pix_bpp), 256'(6'd32));
    acc(1'b1, 8'h14, 8'h13, "R2");
    acc(1'b1, 8'h15, 8'h55, "R3");
    acc(1'b0, 8'h15, 8'h00, "R3 crt readback");
    acc(1'b1, 8'h0E, 8'h05, "R2");
    acc(1'b1, 8'h0F, 8'h40, "R3");
    acc(1'b0, 8'h0F, 8'h00, "R3 gfx readback");
    acc(1'b0, 8'h0E, 8'h00, "R2 gfx index readback");
    chk_outputs("R3");
    // R4: indexes past the end of each bank
    acc(1'b1, 8'h14, 8'h25, "R4");
    acc(1'b1, 8'h15, 8'hAA, "R4");
    acc(1'b0, 8'h15, 8'h00, "R4 crt out of range reads zero");
    acc(1'b1, 8'h0E, 8'h10, "R4");
    acc(1'b1, 8'h0F, 8'hBB, "R4");
    acc(1'b0, 8'h0F, 8'h00, "R4 gfx out of range reads zero");
    acc(1'b1, 8'h04, 8'h08, "R4");
    acc(1'b1, 8'h05, 8'hCC, "R4");
    chk_outputs("R4");
    // R5: unlock and hidden write
    mask_reads(4, "R5");
    acc(1'b1, 8'h06, 8'hC1, "R5");
    chk("R5 hidden reg", 256'(pix_fmt), 256'(8'hC1));
    chk("R5 mask untouched", 256'(pal_mask), 256'(8'h00));
    chk("R8 mode 565", 256'(color_mode), 256'(2'd1));
    // R7: the run restarts after a hidden write
    acc(1'b1, 8'h06, 8'h3C, "R7");
    chk("R7 next write to mask", 256'(pal_mask), 256'(8'h3C));
    chk("R7 hidden held", 256'(pix_fmt), 256'(8'hC1));
    // R6: a foreign access breaks the run
    mask_reads(3, "R6");
    acc(1'b0, 8'h04, 8'h00, "R6");
    mask_reads(1, "R6");
    acc(1'b1, 8'h06, 8'h77, "R6");
    chk("R6 interrupted run to mask", 256'(pal_mask), 256'(8'h77));
    chk("R6 hidden held", 256'(pix_fmt), 256'(8'hC1));
    // R6: an early mask write clears the run
    mask_reads(2, "R6");
    acc(1'b1, 8'h06, 8'h11, "R6");
    mask_reads(2, "R6");
    acc(1'b1, 8'h06, 8'h22, "R6");
    chk("R6 early write clears run", 256'(pal_mask), 256'(8'h22));
    chk("R6 hidden held after early write", 256'(pix_fmt), 256'(8'hC1));
    // R7: reads beyond the fourth stay armed
    mask_reads(6, "R7");
    acc(1'b1, 8'h06, 8'hC5, "R7");
    chk("R7 six reads armed", 256'(pix_fmt), 256'(8'hC5));
    chk("R8 mode direct", 256'(color_mode), 256'(2'd2));
    // R10: idle cycles keep the run armed
    mask_reads(4, "R10");
    idle(3);
    acc(1'b1, 8'h06, 8'h00, "R10");
    chk("R10 idle keeps armed", 256'(pix_fmt), 256'(8'h00));
    chk("R8 mode indexed", 256'(color_mode), 256'(2'd0));
    acc(1'b0, 8'h00, 8'h00, "R10 unmapped reads zero");
    acc(1'b0, 8'h1F, 8'h00, "R10 unmapped reads zero");
    mask_reads(4, "R8");
    acc(1'b1, 8'h06, 8'h42, "R8");
    chk("R8 mode other", 256'(color_mode), 256'(2'd3));
    // R9: the other depth codes
    acc(1'b1, 8'h04, 8'h07, "R9");
    acc(1'b1, 8'h05, 8'h11, "R9");
    chk("R9 bpp 8", 256'(pix_bpp), 256'(6'd8));
    acc(1'b1, 8'h05, 8'hB7, "R9");
    chk("R9 bpp 16", 256'(pix_bpp), 256'(6'd16));
    acc(1'b1, 8'h05, 8'h15, "R9");
    chk("R9 bpp 24", 256'(pix_bpp), 256'(6'd24));
    acc(1'b1, 8'h05, 8'h0A, "R9");
    chk("R9 bpp other", 256'(pix_bpp), 256'(6'd0));
    // Random accesses checked against the model
    for (int n = 0; n < 4000; n++) begin
      int k;
      logic [7:0] a, d;
      logic w;
      k = int'($urandom_range(0, 11));
      a = (k >= 9) ? 8'h06 : pool[k];
      w = ($urandom_range(0, 3) == 0);
      d = 8'($urandom);
      if (a == 8'h04) d = 8'($urandom_range(0, 10));
      if (a == 8'h0E) d = 8'($urandom_range(0, 19));
      if (a == 8'h14) d = 8'($urandom_range(0, 39));
      if (a == 8'h06 && w && $urandom_range(0, 1) == 1) d = ($urandom_range(0, 1) == 1) ? 8'hC1 : 8'hC5;
      if ($urandom_range(0, 15) == 0) idle(1);
      acc(w, a, d, "R3 R5 R6 random");
    end
    chk_outputs("R3 R5 random end");
    done = 1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule